// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Generator

This block sits beside a processor on a bus that is ready unless told otherwise. It captures the bus address while the address latch enable is high. When that enable falls, it matches the captured address against a set of programmable regions. Each region is an inclusive address window with a lower and an upper bound. The matching region's chip select is driven for the whole bus cycle.

Each region carries a wait count from 0 to 3. The count is loaded on the clock edge that first sees the latch enable low. It then counts down once per clock while the read or write strobe is active. Ready is held low until the count reaches zero.

A region may also honour a wait request from the peripheral. That request passes through a two-flop synchronizer, and while the synchronized request is high the processor keeps waiting. Accesses that hit no region get no waits, and the peripheral request is ignored for them. Software sets up the regions through a small write port. Every region is disabled after reset.

Top module: `cs_wait_gen`

## Requirements
- R1: After reset every region is disabled, no chip select is asserted and ready is high.
- R2: The chip select of the matching region (`cs_o[i]` for region i) rises at the first clock edge that samples `bus_ale` low after it was high. It stays high until the first clock edge that samples both strobes low. A region matches when it is enabled and base <= latched address <= limit. The address used is the one present on the last edge where `bus_ale` was high.
- R3: If several regions match, only the lowest-numbered one is selected. At most one chip select is ever high.
- R4: With a programmed count N, ready stays low for exactly N clock samples after the chip select rises, provided the strobe is held. The count decrements only on edges where a strobe is active.
- R5: For a region with the external-wait bit set, ready is also low while the synchronized `ext_wait` is high. The synchronizer adds two clock edges of latency. So a request that has been high for a while and is dropped after the M-th low-ready sample keeps ready low through sample M+1.
- R6: For a region with the external-wait bit clear, `ext_wait` has no effect on ready.
- R7: An access that matches no region asserts no chip select and gets no wait states, whatever `ext_wait` does.
- R8: Ready is high whenever neither strobe is active.
- R9: Configuration writes use `cfg_addr = {region, field}`, where the field is the low 2 bits. Field 0 writes the base. Field 1 writes the limit. Field 2 writes the control word: bits [1:0] are the wait count, bit 2 is the external-wait enable and bit 3 is the region enable. Field 3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W+2 | Region index and field select |
| cfg_wdata | input | ADDR_W | Configuration write data |
| bus_addr | input | ADDR_W | Processor address |
| bus_ale | input | 1 | Address latch enable |
| bus_rd | input | 1 | Read strobe, active high |
| bus_wr | input | 1 | Write strobe, active high |
| ext_wait | input | 1 | Asynchronous wait request from the peripheral |
| cs_o | output | NUM_REGIONS | One chip select per region, active high |
| ready_o | output | 1 | Ready back to the processor |

## Verification
The bench drives inputs on falling edges and samples the outputs on falling edges. Every result is therefore read half a clock after the register that produces it has updated.

The chip select is read at the first falling edge after the edge that sees the latch enable low. Ready is sampled on each later falling edge, and the number of low samples is compared with max(N, M+1) or with N, depending on whether the region honours the request. The chip select is checked clear one falling edge after the strobe is dropped.

For the external request, the bench raises it three cycles before the address phase, so it is already through the synchronizer when the cycle starts.

// File: rtl/cs_wait_pkg.sv
package cs_wait_pkg;

    localparam int WAIT_W = 2;

    localparam logic [1:0] FIELD_BASE  = 2'd0;
    localparam logic [1:0] FIELD_LIMIT = 2'd1;
    localparam logic [1:0] FIELD_CTRL  = 2'd2;

    // control word layout: [3] enable, [2] external wait honoured, [1:0] waits
    typedef struct packed {
        logic              en;
        logic              ext_en;
        logic [WAIT_W-1:0] waits;
    } region_ctrl_t;

endpackage

// File: rtl/cs_region_regs.sv
module cs_region_regs
    import cs_wait_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int CFG_AW     = IDX_W + 2
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 cfg_we,
    input  logic [CFG_AW-1:0]                    cfg_addr,
    input  logic [ADDR_W-1:0]                    cfg_wdata,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   base_o,
    output logic [NUM_REGIONS-1:0][ADDR_W-1:0]   limit_o,
    output region_ctrl_t [NUM_REGIONS-1:0]       ctrl_o
);

    typedef struct packed {
        logic [NUM_REGIONS-1:0][ADDR_W-1:0] base;
        logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit;
        region_ctrl_t [NUM_REGIONS-1:0]     ctrl;
    } regs_t;

    regs_t st_d, st_q;

    logic [IDX_W-1:0] wr_idx;
    logic [1:0]       wr_field;

    assign wr_idx   = cfg_addr[CFG_AW-1:2];
    assign wr_field = cfg_addr[1:0];

    always_comb begin
        st_d = st_q;
        if (cfg_we && (int'(wr_idx) < NUM_REGIONS)) begin
            case (wr_field)
                FIELD_BASE:  st_d.base[wr_idx]  = cfg_wdata;
                FIELD_LIMIT: st_d.limit[wr_idx] = cfg_wdata;
                FIELD_CTRL:  st_d.ctrl[wr_idx]  = region_ctrl_t'(cfg_wdata[WAIT_W+1:0]);
                default:     ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign base_o  = st_q.base;
    assign limit_o = st_q.limit;
    assign ctrl_o  = st_q.ctrl;

    // R1: nothing is enabled in the first cycle after reset
    assert_reset_disabled_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> (st_q.ctrl == '0));

endmodule

// File: rtl/cs_addr_decode.sv
module cs_addr_decode
    import cs_wait_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic [ADDR_W-1:0]                  addr_i,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] base_i,
    input  logic [NUM_REGIONS-1:0][ADDR_W-1:0] limit_i,
    input  region_ctrl_t [NUM_REGIONS-1:0]     ctrl_i,
    output logic                               sel_valid_o,
    output logic [IDX_W-1:0]                   sel_idx_o,
    output logic [NUM_REGIONS-1:0]             sel_onehot_o
);

    logic [NUM_REGIONS-1:0] hit;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_match
        assign hit[g] = ctrl_i[g].en && (addr_i >= base_i[g]) && (addr_i <= limit_i[g]);
    end

    // lowest index wins: scan downward so the last assignment is the smallest hit
    always_comb begin
        sel_valid_o  = 1'b0;
        sel_idx_o    = '0;
        sel_onehot_o = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_valid_o = 1'b1;
                sel_idx_o   = IDX_W'(i);
            end
        end
        if (sel_valid_o) sel_onehot_o[sel_idx_o] = 1'b1;
    end

endmodule

// File: rtl/cs_wait_timer.sv
module cs_wait_timer
    import cs_wait_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale_i,
    input  logic              strobe_i,
    input  logic              ext_wait_i,
    input  logic [WAIT_W-1:0] load_waits_i,
    input  logic              ext_en_i,
    output logic              ready_o,
    output logic              cycle_o
);

    typedef struct packed {
        logic              ale;
        logic              cycle;
        logic [WAIT_W-1:0] cnt;
        logic [1:0]        sync;
    } timer_t;

    timer_t st_d, st_q;
    logic   ale_fall;

    assign ale_fall = st_q.ale && !ale_i;

    always_comb begin
        st_d      = st_q;
        st_d.ale  = ale_i;
        st_d.sync = {st_q.sync[0], ext_wait_i};
        if (ale_fall) begin
            st_d.cycle = 1'b1;
            st_d.cnt   = load_waits_i;
        end else if (st_q.cycle) begin
            if (!strobe_i)               st_d.cycle = 1'b0;
            else if (st_q.cnt != '0)     st_d.cnt   = st_q.cnt - WAIT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ready_o = !(st_q.cycle && strobe_i &&
                       ((st_q.cnt != '0) || (ext_en_i && st_q.sync[1])));
    assign cycle_o = st_q.cycle;

    // R4: one step down per strobed clock while waits remain
    assert_cnt_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cycle && strobe_i && st_q.cnt != '0 && !ale_fall)
        |=> (st_q.cnt == $past(st_q.cnt) - WAIT_W'(1)));

    // R8: no strobe means ready
    assert_ready_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |-> ready_o);

    // R5: a synchronized request on an honouring region holds the processor
    assert_ext_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cycle && strobe_i && ext_en_i && st_q.sync[1]) |-> !ready_o);

endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
    import cs_wait_pkg::*;
#(
    parameter int NUM_REGIONS = 4,
    parameter int ADDR_W      = 16,
    localparam int IDX_W      = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1,
    localparam int CFG_AW     = IDX_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_we,
    input  logic [CFG_AW-1:0]      cfg_addr,
    input  logic [ADDR_W-1:0]      cfg_wdata,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_ale,
    input  logic                   bus_rd,
    input  logic                   bus_wr,
    input  logic                   ext_wait,
    output logic [NUM_REGIONS-1:0] cs_o,
    output logic                   ready_o
);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } latch_t;

    latch_t lat_d, lat_q;

    logic [NUM_REGIONS-1:0][ADDR_W-1:0] base, limit;
    region_ctrl_t [NUM_REGIONS-1:0]     ctrl;
    logic                               sel_valid;
    logic [IDX_W-1:0]                   sel_idx;
    logic [NUM_REGIONS-1:0]             sel_onehot;
    logic [WAIT_W-1:0]                  sel_waits;
    logic                               sel_ext_en;
    logic                               cycle;
    logic                               strobe;

    always_comb begin
        lat_d = lat_q;
        if (bus_ale) lat_d.addr = bus_addr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lat_q <= '0;
        else        lat_q <= lat_d;
    end

    cs_region_regs #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .base_o    (base),
        .limit_o   (limit),
        .ctrl_o    (ctrl)
    );

    cs_addr_decode #(.NUM_REGIONS(NUM_REGIONS), .ADDR_W(ADDR_W)) u_decode (
        .addr_i       (lat_q.addr),
        .base_i       (base),
        .limit_i      (limit),
        .ctrl_i       (ctrl),
        .sel_valid_o  (sel_valid),
        .sel_idx_o    (sel_idx),
        .sel_onehot_o (sel_onehot)
    );

    assign sel_waits  = sel_valid ? ctrl[sel_idx].waits  : '0;
    assign sel_ext_en = sel_valid ? ctrl[sel_idx].ext_en : 1'b0;
    assign strobe     = bus_rd || bus_wr;

    cs_wait_timer u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .ale_i        (bus_ale),
        .strobe_i     (strobe),
        .ext_wait_i   (ext_wait),
        .load_waits_i (sel_waits),
        .ext_en_i     (sel_ext_en),
        .ready_o      (ready_o),
        .cycle_o      (cycle)
    );

    assign cs_o = cycle ? sel_onehot : '0;

    // R3: never two chip selects together
    assert_cs_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o));

    // R2: chip selects only inside a bus cycle
    assert_cs_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cycle |-> (cs_o == '0));

    // R7: an unmatched access is never stretched
    assert_miss_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle && !sel_valid) |-> ready_o);

endmodule

// File: tb/cs_wait_gen_tb.sv
`timescale 1ns/1ps
module cs_wait_gen_tb;

    localparam int NUM = 4;
    localparam int AW  = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_we;
    logic [3:0]    cfg_addr;
    logic [AW-1:0] cfg_wdata;
    logic [AW-1:0] bus_addr;
    logic          bus_ale, bus_rd, bus_wr, ext_wait;
    logic [NUM-1:0] cs_o;
    logic          ready_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_base [NUM];
    int m_limit[NUM];
    int m_waits[NUM];
    bit m_ext  [NUM];
    bit m_en   [NUM];

    always #2 clk = ~clk;

    cs_wait_gen #(.NUM_REGIONS(NUM), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .bus_addr(bus_addr), .bus_ale(bus_ale),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .ext_wait(ext_wait),
        .cs_o(cs_o), .ready_o(ready_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_region(input int a);
        for (int i = 0; i < NUM; i++)
            if (m_en[i] && a >= m_base[i] && a <= m_limit[i]) return i;
        return -1;
    endfunction

    task automatic cfg_write(input int r, input int f, input int data);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {r[1:0], f[1:0]};
        cfg_wdata = data[AW-1:0];
        @(negedge clk);
        cfg_we    = 1'b0;
        case (f)
            0: m_base[r]  = data & 16'hFFFF;
            1: m_limit[r] = data & 16'hFFFF;
            2: begin m_waits[r] = data & 3; m_ext[r] = data[2]; m_en[r] = data[3]; end
            default: ;
        endcase
    endtask

    task automatic set_region(input int r, input int b, input int l, input int w,
                              input bit x, input bit e);
        cfg_write(r, 0, b);
        cfg_write(r, 1, l);
        cfg_write(r, 2, {e, x, w[1:0]});
    endtask

    // one bus cycle; m = low-ready sample after which ext_wait is dropped (m >= 1)
    task automatic bus_cycle(input int a, input bit use_wr, input bit ext_on,
                             input int m, input string req);
        int r, exp_w, got_w, exp_cs;
        logic [NUM-1:0] got_cs;
        bit done_c;
        r      = exp_region(a);
        exp_w  = (r >= 0) ? m_waits[r] : 0;
        if (ext_on && r >= 0 && m_ext[r] && (m + 1) > exp_w) exp_w = m + 1;
        exp_cs = (r >= 0) ? (1 << r) : 0;
        if (ext_on) begin
            @(negedge clk) ext_wait = 1'b1;
            repeat (3) @(negedge clk);
        end
        @(negedge clk);
        bus_addr = a[AW-1:0];
        bus_ale  = 1'b1;
        @(negedge clk);
        bus_ale  = 1'b0;
        bus_addr = AW'($urandom);
        if (use_wr) bus_wr = 1'b1; else bus_rd = 1'b1;
        got_w  = 0;
        done_c = 0;
        got_cs = '0;
        for (int j = 1; j <= 24 && !done_c; j++) begin
            @(negedge clk);
            if (j == 1) got_cs = cs_o;
            if (ready_o) done_c = 1;
            else begin
                got_w++;
                if (ext_on && j == m) ext_wait = 1'b0;
            end
        end
        bus_rd = 1'b0; bus_wr = 1'b0; ext_wait = 1'b0;
        chk(got_cs == exp_cs[NUM-1:0], {req, " R2 chip select"}, int'(got_cs), exp_cs);
        chk(got_w == exp_w, {req, " R4 wait count"}, got_w, exp_w);
        @(negedge clk);
        chk(cs_o == '0, {req, " R2 chip select clears after strobe"}, int'(cs_o), 0);
        chk(ready_o == 1'b1, {req, " R8 ready idle"}, int'(ready_o), 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < NUM; i++) begin
            m_base[i] = 0; m_limit[i] = 0; m_waits[i] = 0; m_ext[i] = 0; m_en[i] = 0;
        end
        rst_n = 1'b0; cfg_we = 0; cfg_addr = '0; cfg_wdata = '0;
        bus_addr = '0; bus_ale = 0; bus_rd = 0; bus_wr = 0; ext_wait = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cs_o == '0, "R1 no chip select", int'(cs_o), 0);
        chk(ready_o == 1'b1, "R1 ready high", int'(ready_o), 1);
        bus_cycle(16'h1234, 0, 1, 2, "R1 disabled after reset");

        // R2/R4: basic region with two waits
        set_region(0, 16'h1000, 16'h1FFF, 2, 0, 1);
        bus_cycle(16'h1800, 0, 0, 1, "R2 R4 region0 read");
        bus_cycle(16'h1000, 1, 0, 1, "R2 base boundary write");
        bus_cycle(16'h1FFF, 0, 0, 1, "R2 limit boundary");
        // R7: miss, external request active but ignored
        bus_cycle(16'h2000, 0, 1, 3, "R7 miss above limit");

        // R3: overlapping region, lower index wins
        set_region(1, 16'h1800, 16'h27FF, 3, 0, 1);
        bus_cycle(16'h1900, 0, 0, 1, "R3 overlap lower wins");
        bus_cycle(16'h2100, 1, 0, 1, "R4 region1 three waits");

        // R5: honoured external request, zero internal waits
        set_region(2, 16'h8000, 16'h8FFF, 0, 1, 1);
        bus_cycle(16'h8010, 0, 1, 3, "R5 ext extends zero-wait region");
        bus_cycle(16'h8FFF, 0, 0, 1, "R5 no request zero waits");
        // R5 with internal count larger than request
        set_region(3, 16'hA000, 16'hA0FF, 3, 1, 1);
        bus_cycle(16'hA000, 1, 1, 1, "R5 count dominates");
        bus_cycle(16'hA0FF, 0, 1, 4, "R5 request dominates");
        // R6: ignoring region
        bus_cycle(16'h1800, 0, 1, 5, "R6 ext ignored region0");

        // R9: field 3 writes nothing; disabling region0 exposes region1
        cfg_write(0, 3, 16'hFFFF);
        bus_cycle(16'h1800, 0, 0, 1, "R9 field3 no effect");
        cfg_write(0, 2, 16'h0002);
        bus_cycle(16'h1800, 0, 0, 1, "R9 region disabled");
        bus_cycle(16'h1200, 0, 1, 2, "R9 disabled region misses");

        // constrained random
        for (int it = 0; it < 300; it++) begin
            if ($urandom_range(0, 4) == 0) begin
                int r, b, l;
                r = $urandom_range(0, NUM - 1);
                b = $urandom_range(0, 15) << 12;
                l = b + $urandom_range(0, 16'h2FFF);
                if (l > 16'hFFFF) l = 16'hFFFF;
                set_region(r, b, l, $urandom_range(0, 3), 1'($urandom_range(0, 1)),
                           1'($urandom_range(0, 4) != 0));
            end
            bus_cycle(($urandom_range(0, 15) << 12) | $urandom_range(0, 16'h0FFF),
                      1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                      $urandom_range(1, 5), "random");
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule